// File: doc/BRIEF.md
# Fixed-Point DSP Arithmetic-Logic Unit with Condition Flags

This block is the arithmetic-logic stage of a fixed-point signal processor. Each issued instruction carries a 4-bit operation code. The unit combines the low word of the accumulator with the low word of the product register, or the full extended values of both, and writes the outcome into a 48-bit result register. In the same edge it updates four condition flags: sign, zero, carry and overflow.

Most operations work on one 32-bit word: bitwise AND, OR and XOR, add, subtract, and five shift and rotate forms, one of which rotates a whole byte. The result register holds these results zero-extended. The double-width add works on all 48 bits. It places its sign and carry at the wide positions. Unused and no-operation codes leave every piece of state alone, so code can be padded freely.

The surrounding datapath presents the accumulator halves, the product halves and the operation code, then pulses `issue` for one cycle per instruction. The new result and flags appear on the outputs after that clock edge.

Top module: `dsp_flag_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the result and all four flags become zero, whatever the other inputs carry.
- R2: Operation codes: 0 none, 1 AND, 2 OR, 3 XOR, 4 ADD, 5 SUB, 6 double add, 8 arithmetic shift right, 9 rotate right, 10 shift left, 11 rotate left, 15 byte rotate left.
- R3: Codes 0, 7, 12, 13 and 14 leave the result and all four flags unchanged.
- R4: AND, OR and XOR combine `acc_lo` with `prod_lo`. They clear carry, set sign from bit 31 of the result, set zero when the 32-bit result is zero, and keep overflow.
- R5: ADD forms `acc_lo + prod_lo`. Carry is bit 32 of the unsigned 33-bit sum. Overflow is set when both operands have the same sign and the result's bit 31 differs from it. Sign and zero come from the 32-bit result.
- R6: SUB forms `acc_lo - prod_lo`. Carry is bit 32 of the 33-bit difference, so it is 1 on a borrow. Overflow is set when the operand signs differ and the result's bit 31 differs from that of `acc_lo`. Sign and zero come from the 32-bit result.
- R7: The double add forms `{prod_hi,prod_lo} + {acc_hi,acc_lo}` over 48 bits. Sign is bit 47, carry is bit 48 of the unsigned sum, zero reflects all 48 result bits, and overflow is 48-bit signed overflow.
- R8: The arithmetic shift right moves `acc_lo` right by one and keeps bit 31. Carry takes the old bit 0.
- R9: The rotate right moves old bit 0 of `acc_lo` into bit 31, and carry takes the old bit 0.
- R10: The shift left brings in 0 at bit 0. The rotate left brings in old bit 31 at bit 0. Both load carry with old bit 31.
- R11: The byte rotate moves `acc_lo` left by eight places, with old bits 31:24 landing in bits 7:0. Carry takes the old bit 24.
- R12: Every 32-bit operation writes its result with bits 47:32 at zero. The sign is never extended.
- R13: Shift and rotate operations keep overflow. They set sign from bit 31 and zero from the 32-bit result.
- R14: State changes only at a clock edge where `issue` is high. The outputs show the new values from that edge until the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | One instruction is executed at this edge |
| opcode | input | 4 | Operation code |
| acc_hi | input | 16 | Accumulator high part |
| acc_lo | input | 32 | Accumulator low word |
| prod_hi | input | 16 | Product register high part |
| prod_lo | input | 32 | Product register low word |
| alu_res | output | 48 | Registered result |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench drives the signed-overflow edges for both word adds and the double add. It also drives an unsigned wrap to zero, which must raise carry and zero together, and a subtract that borrows. A design that took carry or sign from the wrong bit position, or that tested overflow at 32 bits during the double add, would show wrong flags on these vectors. The shift vectors put distinct values in bits 0, 24 and 31, so a carry loaded from the wrong end, or a right shift that drops the sign, shows up. No-operation codes, undefined codes and idle cycles are placed straight after flag-setting operations, so any stray update is visible, and a sign-extended 32-bit result would corrupt bits 47:32.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;

  localparam logic [3:0] OP_NONE = 4'h0;
  localparam logic [3:0] OP_AND  = 4'h1;
  localparam logic [3:0] OP_OR   = 4'h2;
  localparam logic [3:0] OP_XOR  = 4'h3;
  localparam logic [3:0] OP_ADD  = 4'h4;
  localparam logic [3:0] OP_SUB  = 4'h5;
  localparam logic [3:0] OP_DADD = 4'h6;
  localparam logic [3:0] OP_ASR  = 4'h8;
  localparam logic [3:0] OP_ROR  = 4'h9;
  localparam logic [3:0] OP_SHL  = 4'hA;
  localparam logic [3:0] OP_ROL  = 4'hB;
  localparam logic [3:0] OP_ROLB = 4'hF;

  typedef enum logic [1:0] {
    GRP_IDLE  = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_ARITH = 2'd2,
    GRP_SHIFT = 2'd3
  } alu_grp_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;

  function automatic alu_grp_e grp_of(input logic [3:0] op);
    case (op)
      OP_AND, OP_OR, OP_XOR:                  return GRP_LOGIC;
      OP_ADD, OP_SUB, OP_DADD:                return GRP_ARITH;
      OP_ASR, OP_ROR, OP_SHL, OP_ROL, OP_ROLB: return GRP_SHIFT;
      default:                                return GRP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import dsp_alu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [3:0]        op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] res,
  output alu_flags_t        flags
);

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
    flags.s = res[WORD_W-1];
    flags.z = (res == '0);
    flags.c = 1'b0;
    flags.v = 1'b0;
  end

endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import dsp_alu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EXT_W  = 16
) (
  input  logic [3:0]               op,
  input  logic [EXT_W-1:0]         acc_hi,
  input  logic [WORD_W-1:0]        acc_lo,
  input  logic [EXT_W-1:0]         prod_hi,
  input  logic [WORD_W-1:0]        prod_lo,
  output logic [WORD_W+EXT_W-1:0]  res,
  output alu_flags_t               flags
);

  localparam int FULL_W = WORD_W + EXT_W;
  localparam int WM     = WORD_W - 1;
  localparam int FM     = FULL_W - 1;

  logic [WORD_W:0] sum_w;
  logic [WORD_W:0] dif_w;
  logic [FULL_W:0] sum_d;
  logic [FM:0]     wide_a;
  logic [FM:0]     wide_b;
  logic            ovf_add;
  logic            ovf_sub;
  logic            ovf_dbl;

  assign wide_a = {acc_hi, acc_lo};
  assign wide_b = {prod_hi, prod_lo};
  assign sum_w  = {1'b0, acc_lo} + {1'b0, prod_lo};
  assign dif_w  = {1'b0, acc_lo} - {1'b0, prod_lo};
  assign sum_d  = {1'b0, wide_a} + {1'b0, wide_b};

  assign ovf_add = ~(acc_lo[WM] ^ prod_lo[WM]) & (acc_lo[WM] ^ sum_w[WM]);
  assign ovf_sub =  (acc_lo[WM] ^ prod_lo[WM]) & (acc_lo[WM] ^ dif_w[WM]);
  assign ovf_dbl = ~(wide_a[FM] ^ wide_b[FM])  & (wide_a[FM] ^ sum_d[FM]);

  always_comb begin
    res   = '0;
    flags = '0;
    case (op)
      OP_ADD: begin
        res     = {{EXT_W{1'b0}}, sum_w[WM:0]};
        flags.s = sum_w[WM];
        flags.z = (sum_w[WM:0] == '0);
        flags.c = sum_w[WORD_W];
        flags.v = ovf_add;
      end
      OP_SUB: begin
        res     = {{EXT_W{1'b0}}, dif_w[WM:0]};
        flags.s = dif_w[WM];
        flags.z = (dif_w[WM:0] == '0);
        flags.c = dif_w[WORD_W];
        flags.v = ovf_sub;
      end
      OP_DADD: begin
        res     = sum_d[FM:0];
        flags.s = sum_d[FM];
        flags.z = (sum_d[FM:0] == '0);
        flags.c = sum_d[FULL_W];
        flags.v = ovf_dbl;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import dsp_alu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROT_B  = 8
) (
  input  logic [3:0]        op,
  input  logic [WORD_W-1:0] a,
  output logic [WORD_W-1:0] res,
  output alu_flags_t        flags
);

  localparam int WM = WORD_W - 1;

  logic [WM:0] rot_r1;
  logic [WM:0] rot_l1;
  logic [WM:0] rot_lb;

  for (genvar i = 0; i < WORD_W; i++) begin : g_rot
    assign rot_r1[i] = a[(i + 1) % WORD_W];
    assign rot_l1[i] = a[(i + WORD_W - 1) % WORD_W];
    assign rot_lb[i] = a[(i + WORD_W - ROT_B) % WORD_W];
  end

  always_comb begin
    res     = '0;
    flags.c = 1'b0;
    case (op)
      OP_ASR: begin
        res     = {a[WM], a[WM:1]};
        flags.c = a[0];
      end
      OP_ROR: begin
        res     = rot_r1;
        flags.c = a[0];
      end
      OP_SHL: begin
        res     = {a[WM-1:0], 1'b0};
        flags.c = a[WM];
      end
      OP_ROL: begin
        res     = rot_l1;
        flags.c = a[WM];
      end
      OP_ROLB: begin
        res     = rot_lb;
        flags.c = a[WORD_W - ROT_B];
      end
      default: ;
    endcase
    flags.s = res[WM];
    flags.z = (res == '0);
    flags.v = 1'b0;
  end

endmodule

// File: rtl/dsp_flag_alu.sv
module dsp_flag_alu
  import dsp_alu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EXT_W  = 16,
  parameter int ROT_B  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      issue,
  input  logic [3:0]                opcode,
  input  logic [EXT_W-1:0]          acc_hi,
  input  logic [WORD_W-1:0]         acc_lo,
  input  logic [EXT_W-1:0]          prod_hi,
  input  logic [WORD_W-1:0]         prod_lo,
  output logic [WORD_W+EXT_W-1:0]   alu_res,
  output logic                      flag_s,
  output logic                      flag_z,
  output logic                      flag_c,
  output logic                      flag_v
);

  localparam int FULL_W = WORD_W + EXT_W;

  alu_grp_e          grp;
  logic [WORD_W-1:0] log_res;
  logic [WORD_W-1:0] shf_res;
  logic [FULL_W-1:0] ari_res;
  alu_flags_t        log_flg;
  alu_flags_t        shf_flg;
  alu_flags_t        ari_flg;
  logic [FULL_W-1:0] nxt_res;
  alu_flags_t        nxt_flg;
  logic [FULL_W-1:0] res_q;
  alu_flags_t        flg_q;

  assign grp = grp_of(opcode);

  alu_logic_unit #(.WORD_W(WORD_W)) u_logic (
    .op(opcode), .a(acc_lo), .b(prod_lo), .res(log_res), .flags(log_flg)
  );

  alu_arith_unit #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_arith (
    .op(opcode), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .prod_hi(prod_hi), .prod_lo(prod_lo), .res(ari_res), .flags(ari_flg)
  );

  alu_shift_unit #(.WORD_W(WORD_W), .ROT_B(ROT_B)) u_shift (
    .op(opcode), .a(acc_lo), .res(shf_res), .flags(shf_flg)
  );

  always_comb begin
    nxt_res = res_q;
    nxt_flg = flg_q;
    case (grp)
      GRP_LOGIC: begin
        nxt_res = {{EXT_W{1'b0}}, log_res};
        nxt_flg = '{s: log_flg.s, z: log_flg.z, c: log_flg.c, v: flg_q.v};
      end
      GRP_SHIFT: begin
        nxt_res = {{EXT_W{1'b0}}, shf_res};
        nxt_flg = '{s: shf_flg.s, z: shf_flg.z, c: shf_flg.c, v: flg_q.v};
      end
      GRP_ARITH: begin
        nxt_res = ari_res;
        nxt_flg = ari_flg;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (issue) begin
      res_q <= nxt_res;
      flg_q <= nxt_flg;
    end
  end

  assign alu_res = res_q;
  assign flag_s  = flg_q.s;
  assign flag_z  = flg_q.z;
  assign flag_c  = flg_q.c;
  assign flag_v  = flg_q.v;

endmodule

// File: rtl/dsp_flag_alu_chk.sv
module dsp_flag_alu_chk #(
  parameter int WORD_W = 32,
  parameter int EXT_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     issue,
  input logic [3:0]               opcode,
  input logic [WORD_W-1:0]        acc_lo,
  input logic [WORD_W+EXT_W-1:0]  alu_res,
  input logic                     flag_s,
  input logic                     flag_z,
  input logic                     flag_c,
  input logic                     flag_v
);

  localparam int FULL_W = WORD_W + EXT_W;
  localparam int WM     = WORD_W - 1;

  logic is_hold, is_logic, is_shift, is_word;
  assign is_hold  = opcode inside {4'h0, 4'h7, 4'hC, 4'hD, 4'hE};
  assign is_logic = opcode inside {4'h1, 4'h2, 4'h3};
  assign is_shift = opcode inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hF};
  assign is_word  = is_logic || is_shift || opcode inside {4'h4, 4'h5};

  a_r3_hold_codes: assert property (@(posedge clk) disable iff (rst)
    issue && is_hold |=> $stable(alu_res) && $stable(flag_s) && $stable(flag_z)
                         && $stable(flag_c) && $stable(flag_v));

  a_r14_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !issue |=> $stable(alu_res) && $stable(flag_s) && $stable(flag_z)
               && $stable(flag_c) && $stable(flag_v));

  a_r12_zero_ext: assert property (@(posedge clk) disable iff (rst)
    issue && is_word |=> alu_res[FULL_W-1:WORD_W] == '0);

  a_r4_logic_flags: assert property (@(posedge clk) disable iff (rst)
    issue && is_logic |=> !flag_c && $stable(flag_v) && flag_s == alu_res[WM]
                          && flag_z == (alu_res[WM:0] == '0));

  a_r13_shift_flags: assert property (@(posedge clk) disable iff (rst)
    issue && is_shift |=> $stable(flag_v) && flag_s == alu_res[WM]
                          && flag_z == (alu_res[WM:0] == '0));

  a_r7_wide_flags: assert property (@(posedge clk) disable iff (rst)
    issue && opcode == 4'h6 |=> flag_s == alu_res[FULL_W-1] && flag_z == (alu_res == '0));

  a_r8_asr_sign: assert property (@(posedge clk) disable iff (rst)
    issue && opcode == 4'h8 |=> alu_res[WM] == $past(acc_lo[WM]) && flag_c == $past(acc_lo[0]));

  a_r11_byte_rot: assert property (@(posedge clk) disable iff (rst)
    issue && opcode == 4'hF |=> alu_res[7:0] == $past(acc_lo[WM:WORD_W-8])
                                && flag_c == $past(acc_lo[WORD_W-8]));

endmodule

bind dsp_flag_alu dsp_flag_alu_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst(rst), .issue(issue), .opcode(opcode), .acc_lo(acc_lo),
  .alu_res(alu_res), .flag_s(flag_s), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/test_dsp_flag_alu.sv
`timescale 1ns/1ps
module test_dsp_flag_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [15:0] acc_hi = '0, prod_hi = '0;
  logic [31:0] acc_lo = '0, prod_lo = '0;
  logic [47:0] alu_res;
  logic        flag_s, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dsp_flag_alu i_dsp_flag_alu (
    .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .prod_hi(prod_hi), .prod_lo(prod_lo),
    .alu_res(alu_res), .flag_s(flag_s), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // behavioural reference, updated at each rising edge
  logic [47:0] m_res;
  logic        m_s, m_z, m_c, m_v;

  always @(posedge clk) begin
    longint unsigned a, b, t;
    if (rst) begin
      m_res = '0; m_s = 0; m_z = 0; m_c = 0; m_v = 0;
    end else if (issue) begin
      a = longint'(acc_lo);
      b = longint'(prod_lo);
      case (opcode)
        4'h1, 4'h2, 4'h3: begin
          t = (opcode == 4'h1) ? (a & b) : (opcode == 4'h2) ? (a | b) : (a ^ b);
          m_res = t[47:0]; m_c = 0;
          m_s = t[31]; m_z = (t == 0);
        end
        4'h4, 4'h5: begin
          t = (opcode == 4'h4) ? (a + b) : (a - b);
          m_res = {16'h0, t[31:0]};
          m_c = t[32]; m_s = t[31]; m_z = (t[31:0] == 0);
          if (opcode == 4'h4) m_v = (a[31] == b[31]) && (t[31] != a[31]);
          else                m_v = (a[31] != b[31]) && (t[31] != a[31]);
        end
        4'h6: begin
          a = {16'h0, acc_hi, acc_lo};
          b = {16'h0, prod_hi, prod_lo};
          t = a + b;
          m_res = t[47:0]; m_c = t[48]; m_s = t[47]; m_z = (t[47:0] == 0);
          m_v = (a[47] == b[47]) && (t[47] != a[47]);
        end
        4'h8, 4'h9, 4'hA, 4'hB, 4'hF: begin
          case (opcode)
            4'h8: begin t = (a >> 1) | (a & 64'h8000_0000); m_c = a[0]; end
            4'h9: begin t = (a >> 1) | (longint'(a[0]) << 31); m_c = a[0]; end
            4'hA: begin t = (a << 1) & 64'hFFFF_FFFF; m_c = a[31]; end
            4'hB: begin t = ((a << 1) & 64'hFFFF_FFFF) | (a >> 31); m_c = a[31]; end
            default: begin t = ((a << 8) & 64'hFFFF_FFFF) | (a >> 24); m_c = a[24]; end
          endcase
          m_res = t[47:0]; m_s = t[31]; m_z = (t == 0);
        end
        default: ;
      endcase
    end
  end

  function automatic string tag_of(input logic iss, input logic [3:0] op);
    if (!iss) return "R14";
    case (op)
      4'h1, 4'h2, 4'h3: return "R4";
      4'h4: return "R5";
      4'h5: return "R6";
      4'h6: return "R7";
      4'h8: return "R8";
      4'h9: return "R9";
      4'hA, 4'hB: return "R10";
      4'hF: return "R11";
      default: return "R3";
    endcase
  endfunction

  string pend_tag = "R1";

  task automatic compare(input string tag);
    checks++;
    if (alu_res !== m_res || flag_s !== m_s || flag_z !== m_z ||
        flag_c !== m_c || flag_v !== m_v) begin
      fails++;
      $display("FAIL %s (R2/R12/R13): got res=%h szcv=%b%b%b%b expected res=%h szcv=%b%b%b%b",
               tag, alu_res, flag_s, flag_z, flag_c, flag_v, m_res, m_s, m_z, m_c, m_v);
    end
  endtask

  task automatic step(input logic iss, input logic [3:0] op, input logic [15:0] ah,
                      input logic [31:0] al, input logic [15:0] ph, input logic [31:0] pl);
    @(negedge clk);
    compare(pend_tag);
    issue = iss; opcode = op; acc_hi = ah; acc_lo = al; prod_hi = ph; prod_lo = pl;
    pend_tag = tag_of(iss, op);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset wins over an issued add
    issue = 1; opcode = 4'h4; acc_lo = 32'h1234_5678; prod_lo = 32'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (alu_res !== '0 || {flag_s, flag_z, flag_c, flag_v} !== 4'b0) begin
      fails++;
      $display("FAIL R1: got res=%h flags=%b expected res=0 flags=0000", alu_res,
               {flag_s, flag_z, flag_c, flag_v});
    end
    rst = 0; issue = 0;
    pend_tag = "R14";
    // R5 overflow and carry/zero wrap
    step(1, 4'h4, 16'h0, 32'h7FFF_FFFF, 16'h0, 32'h1);
    step(1, 4'h4, 16'h0, 32'hFFFF_FFFF, 16'h0, 32'h1);
    step(1, 4'h0, 16'hFFFF, 32'h5, 16'hFFFF, 32'h9);       // R3 hold after C,Z
    // R6 borrow and overflow
    step(1, 4'h5, 16'h0, 32'h0, 16'h0, 32'h1);
    step(1, 4'h5, 16'h0, 32'h8000_0000, 16'h0, 32'h1);
    step(1, 4'h7, 16'h1, 32'h1, 16'h1, 32'h1);             // R3 undefined
    // R4 logic keeps V, clears C
    step(1, 4'h1, 16'h0, 32'hF0F0_F0F0, 16'h0, 32'h0F0F_0F0F);
    step(1, 4'h2, 16'hFFFF, 32'h8000_0000, 16'hFFFF, 32'h1);
    step(1, 4'h3, 16'h0, 32'hDEAD_BEEF, 16'h0, 32'hDEAD_BEEF);
    // R7 wide add: overflow, wrap with carry and zero
    step(1, 4'h6, 16'h7FFF, 32'hFFFF_FFFF, 16'h0, 32'h1);
    step(1, 4'h6, 16'hFFFF, 32'hFFFF_FFFF, 16'h0, 32'h1);
    step(1, 4'hC, 16'h0, 32'h0, 16'h0, 32'h0);             // R3
    step(1, 4'h6, 16'h0001, 32'h8000_0000, 16'h0002, 32'h8000_0000);
    // R8..R11 shifts; R13 V held
    step(1, 4'h8, 16'h0, 32'h8000_0001, 16'h0, 32'h0);
    step(1, 4'h9, 16'h0, 32'h0000_0001, 16'h0, 32'h0);
    step(1, 4'hA, 16'h0, 32'h8000_0000, 16'h0, 32'h0);
    step(1, 4'hB, 16'h0, 32'h8000_0002, 16'h0, 32'h0);
    step(1, 4'hF, 16'h0, 32'h0100_00FF, 16'h0, 32'h0);
    step(1, 4'hF, 16'h0, 32'hA5FF_0000, 16'h0, 32'h0);
    step(0, 4'h4, 16'h0, 32'h1, 16'h0, 32'h1);             // R14 idle
    step(1, 4'hD, 16'h0, 32'h1, 16'h0, 32'h1);
    step(1, 4'hE, 16'h0, 32'h1, 16'h0, 32'h1);
    // randomized traffic, R2 across all codes
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r0, r1, r2;
      r0 = $urandom; r1 = $urandom; r2 = $urandom;
      step(($urandom % 5) != 0, 4'($urandom), r2[15:0], r0, r2[31:16], r1);
    end
    step(0, 4'h0, 16'h0, 32'h0, 16'h0, 32'h0);
    step(0, 4'h0, 16'h0, 32'h0, 16'h0, 32'h0);
    finish_run();
  end

endmodule